// File: doc/BRIEF.md
# Infrared Serial Receive Pulse Decoder

This block turns the receive line of an infrared serial link into the level-coded stream that an ordinary UART receiver expects. On the infrared side a logic 0 is a short low pulse inside its bit period, and a logic 1 is a bit period with no pulse. The decoder watches the raw line on every system clock, so pulses much narrower than one baud tick are still caught. It keeps a free-running tick counter that wraps every 16 ticks of a baud-rate enable running at sixteen times the bit rate. Every accepted pulse pulls that counter back to zero, so the counter follows the far end's timing even when it drifts.

Pulses are only believed inside an acceptance window around the time the next bit is expected. The window runs from 4 ticks before that time until the counter reaches 8 after it. Pulses outside the window are treated as noise and have no effect. The decoded level for a bit is presented when the counter reaches 8, so the output runs half a bit behind the line. A controller with four named states handles this. IDLE means the window is always open, with no bit timing yet. HOLD means a pulse has been taken and a 0 is pending. GAP means the window is closed, at counts 8 to 11. OPEN means the window is open, at counts 12 to 15 and 0 to 7.

The transitions are as follows:
- IDLE to HOLD on an accepted edge.
- HOLD to GAP when the count reaches 8, which drives the output low.
- GAP to OPEN when the count reaches 12.
- OPEN to HOLD on an accepted edge.
- OPEN to GAP when the count reaches 8 with no pulse, which drives the output high.
- OPEN to IDLE instead of GAP when that no-pulse bit is the twelfth 1 in a row, so a start pulse that arrives at any time is taken.

Disable and reset both force IDLE.

Top module: `irx_decoder`

## Requirements
- R1: While `rst` is high or `en` is low, `rxd` is 1, the tick counter is 0 and the state is IDLE. A falling edge on `ir_rx_n` during that time has no effect once the block runs again.
- R2: In IDLE, a falling edge on `ir_rx_n` at any time is accepted. `rxd` goes to 0 on the eighth `baud_tick` after acceptance and is still 1 after the seventh.
- R3: An accepted pulse decodes as one bit of 0 on `rxd`, lasting 16 ticks unless the next pulse moves the timing.
- R4: A bit period whose window closes with no accepted pulse decodes as 1, and `rxd` rises when the count reaches 8.
- R5: In OPEN, a falling edge from 4 ticks before to 7 ticks after the expected bit time is accepted and clears the counter. The next expected bit time is then 16 ticks after that edge.
- R6: A falling edge in GAP is ignored, which covers 5 to 8 ticks early and exactly 8 ticks late. It neither clears the counter nor produces a 0.
- R7: A falling edge while a 0 is pending in HOLD is ignored.
- R8: The raw line passes through a two-flop synchroniser that samples it on every system clock. A low pulse of two system clocks, shorter than one tick, is detected.
- R9: After 12 consecutive decoded 1 bits the decoder returns to IDLE. An edge at a time that would fall in GAP is then accepted.
- R10: `rxd` changes only on a `baud_tick` where the count reaches 8, or through reset or disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Decoder enable; low holds the idle condition |
| baud_tick | input | 1 | One-cycle enable at 16 times the bit rate |
| ir_rx_n | input | 1 | Raw infrared receive line, pulses active low |
| rxd | output | 1 | Decoded serial line for a UART receiver, idle high |

## Verification
The hardest situations to reach are the ones where an edge has to land at a specific counter value while the timing itself keeps moving. Examples are a pulse exactly 8 ticks late, one 5 ticks early, a glitch while a 0 is pending, and a start edge that only succeeds because twelve idle bits have put the decoder back in IDLE. The stimulus counts baud ticks itself. Each table row is turned into an anchor tick that moves to the real pulse when the pulse is accepted and advances by 16 otherwise. Every pulse is placed at an exact tick offset from the previous anchor, so each of these counter values is hit on purpose.

// File: rtl/irx_pkg.sv
package irx_pkg;

    // Controller states of the receive decoder
    typedef enum logic [1:0] {
        IRX_IDLE = 2'd0,   // no bit timing, window always open
        IRX_HOLD = 2'd1,   // pulse taken, zero pending until mid-bit
        IRX_GAP  = 2'd2,   // window closed between mid-bit and early limit
        IRX_OPEN = 2'd3    // window open around the expected bit time
    } irx_state_e;

endpackage

// File: rtl/irx_sync.sv
module irx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic ir_raw_n,
    output logic fall_o
);

    logic [STAGES-1:0] chain;
    logic              last_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst || !en) chain[0] <= 1'b1;
                else            chain[0] <= ir_raw_n;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst || !en) chain[g] <= 1'b1;
                else            chain[g] <= chain[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) last_q <= 1'b1;
        else            last_q <= chain[STAGES-1];
    end

    // high then low on consecutive synchronised samples
    assign fall_o = last_q & ~chain[STAGES-1];

    // R8: an edge is reported for one cycle only
    a_r8_single_fall: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o);

endmodule

// File: rtl/irx_tick_ctr.sv
module irx_tick_ctr #(
    parameter int TICKS = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic                     tick,
    input  logic                     clr,
    output logic [$clog2(TICKS)-1:0] cnt_o
);

    localparam int              CW   = $clog2(TICKS);
    localparam logic [CW-1:0]   LAST = CW'(TICKS - 1);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_o <= '0;
        end else if (clr) begin
            cnt_o <= '0;
        end else if (tick) begin
            if (cnt_o == LAST) cnt_o <= '0;
            else               cnt_o <= cnt_o + CW'(1);
        end
    end

    // R5: the counter wraps after the last tick of a bit
    a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
        (en && tick && !clr && cnt_o == LAST) |=> cnt_o == '0);

endmodule

// File: rtl/irx_ctrl.sv
module irx_ctrl
    import irx_pkg::*;
#(
    parameter int TICKS     = 16,
    parameter int EARLY     = 4,
    parameter int IDLE_ONES = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic                     tick,
    input  logic                     fall,
    input  logic [$clog2(TICKS)-1:0] cnt,
    output logic                     accept_o,
    output logic                     rxd_o,
    output irx_state_e               state_o
);

    localparam int            CW       = $clog2(TICKS);
    localparam logic [CW-1:0] MID_PRE  = CW'(TICKS / 2 - 1);
    localparam logic [CW-1:0] OPEN_PRE = CW'(TICKS - EARLY - 1);
    localparam int            OW       = $clog2(IDLE_ONES + 1);
    localparam logic [OW-1:0] ONES_MAX = OW'(IDLE_ONES);
    localparam logic [OW-1:0] ONES_PRE = OW'(IDLE_ONES - 1);

    irx_state_e    st, nxt;
    logic [OW-1:0] ones_q;
    logic          at_mid, at_open;

    assign at_mid   = tick && (cnt == MID_PRE);
    assign at_open  = tick && (cnt == OPEN_PRE);
    assign accept_o = fall && ((st == IRX_IDLE) || (st == IRX_OPEN));
    assign state_o  = st;

    // next-state decision
    always_comb begin
        nxt = st;
        unique case (st)
            IRX_IDLE: if (accept_o) nxt = IRX_HOLD;
            IRX_HOLD: if (at_mid)   nxt = IRX_GAP;
            IRX_GAP:  if (at_open)  nxt = IRX_OPEN;
            IRX_OPEN: begin
                if (accept_o)                      nxt = IRX_HOLD;
                else if (at_mid && ones_q == ONES_PRE) nxt = IRX_IDLE;
                else if (at_mid)                   nxt = IRX_GAP;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst || !en) st <= IRX_IDLE;
        else            st <= nxt;
    end

    // decoded line and run length of ones
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            rxd_o  <= 1'b1;
            ones_q <= '0;
        end else begin
            unique case (st)
                IRX_IDLE: if (accept_o) ones_q <= '0;
                IRX_HOLD: if (at_mid)   rxd_o  <= 1'b0;
                IRX_GAP:  ;
                IRX_OPEN: begin
                    if (accept_o) begin
                        ones_q <= '0;
                    end else if (at_mid) begin
                        rxd_o <= 1'b1;
                        if (ones_q != ONES_MAX) ones_q <= ones_q + OW'(1);
                    end
                end
            endcase
        end
    end

    // R3: a pending pulse becomes a zero at mid-bit
    a_r3_zero_at_mid: assert property (@(posedge clk) disable iff (rst)
        (en && st == IRX_HOLD && at_mid) |=> !rxd_o);

    // R4: a window that closes empty yields a one
    a_r4_one_at_mid: assert property (@(posedge clk) disable iff (rst)
        (en && st == IRX_OPEN && at_mid && !accept_o) |=> rxd_o);

    // R10: the line only moves at mid-bit, reset or disable
    a_r10_moves_on_mid: assert property (@(posedge clk) disable iff (rst)
        (rxd_o != $past(rxd_o)) |-> ($past(at_mid) || $past(rst) || !$past(en)));

    // R9: the run counter never passes its limit
    a_r9_ones_bound: assert property (@(posedge clk) disable iff (rst)
        ones_q <= ONES_MAX);

endmodule

// File: rtl/irx_decoder.sv
module irx_decoder
    import irx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    parameter int EARLY_TICKS   = 4,
    parameter int SYNC_STAGES   = 2,
    parameter int IDLE_ONES     = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic baud_tick,
    input  logic ir_rx_n,
    output logic rxd
);

    localparam int CW = $clog2(TICKS_PER_BIT);

    logic          fall;
    logic          accept;
    logic [CW-1:0] cnt;
    irx_state_e    state;

    irx_sync #(
        .STAGES   (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .ir_raw_n (ir_rx_n),
        .fall_o   (fall)
    );

    irx_tick_ctr #(
        .TICKS (TICKS_PER_BIT)
    ) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .tick  (baud_tick),
        .clr   (accept),
        .cnt_o (cnt)
    );

    irx_ctrl #(
        .TICKS     (TICKS_PER_BIT),
        .EARLY     (EARLY_TICKS),
        .IDLE_ONES (IDLE_ONES)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .tick     (baud_tick),
        .fall     (fall),
        .cnt      (cnt),
        .accept_o (accept),
        .rxd_o    (rxd),
        .state_o  (state)
    );

    // R1: disable returns the line high and the counter to zero
    a_r1_disabled_idle: assert property (@(posedge clk) disable iff (rst)
        !en |=> (rxd && cnt == '0 && state == IRX_IDLE));

    // R5: an accepted edge resynchronises the counter
    a_r5_resync: assert property (@(posedge clk) disable iff (rst)
        (en && accept) |=> cnt == '0);

    // R6: an edge in the closed gap leaves the counter alone
    a_r6_gap_ignores: assert property (@(posedge clk) disable iff (rst)
        (en && fall && state == IRX_GAP && !baud_tick) |=> cnt == $past(cnt));

    // R7: an edge while a zero is pending leaves the counter alone
    a_r7_pending_ignores: assert property (@(posedge clk) disable iff (rst)
        (en && fall && state == IRX_HOLD && !baud_tick) |=> cnt == $past(cnt));

endmodule

// File: tb/test_irx_decoder.sv
module test_irx_decoder;

    localparam int DIV = 4;    // system clocks per baud tick
    localparam int TPB = 16;   // ticks per bit
    localparam int NV  = 15;

    typedef struct packed {
        logic              drv;   // drive a pulse in this slot
        logic              exp;   // expected decoded bit
        logic signed [7:0] off;   // pulse offset from expected time
        logic        [7:0] gl;    // glitch tick after anchor, 0 = none
    } vec_t;

    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b0,  8'sd0, 8'd0},
        '{1'b0, 1'b1,  8'sd0, 8'd0},
        '{1'b1, 1'b0, -8'sd4, 8'd0},
        '{1'b1, 1'b0,  8'sd7, 8'd0},
        '{1'b0, 1'b1,  8'sd0, 8'd9},
        '{1'b1, 1'b0,  8'sd0, 8'd3},
        '{1'b1, 1'b1, -8'sd5, 8'd0},
        '{1'b1, 1'b1,  8'sd8, 8'd0},
        '{1'b1, 1'b0,  8'sd0, 8'd0},
        '{1'b1, 1'b0,  8'sd5, 8'd10},
        '{1'b0, 1'b1,  8'sd0, 8'd0},
        '{1'b0, 1'b1,  8'sd0, 8'd0},
        '{1'b1, 1'b0, -8'sd2, 8'd0},
        '{1'b1, 1'b0,  8'sd3, 8'd0},
        '{1'b0, 1'b1,  8'sd0, 8'd0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b1;
    logic baud_tick = 1'b0;
    logic ir_rx_n = 1'b1;
    logic rxd;

    int tick_no = 0;
    int div_cnt = 0;
    int checks = 0;
    int errors = 0;
    int anc [NV+1];
    bit done = 1'b0;

    always #10 clk = ~clk;

    irx_decoder i_irx_decoder (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .baud_tick (baud_tick),
        .ir_rx_n   (ir_rx_n),
        .rxd       (rxd)
    );

    initial begin
        forever begin
            @(negedge clk);
            baud_tick = (div_cnt == DIV - 1);
            div_cnt = (div_cnt + 1) % DIV;
        end
    end

    always @(posedge clk) if (baud_tick) tick_no <= tick_no + 1;

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: rxd=%0b expected %0b at tick %0d", tag, act, exp, tick_no);
        end
    endtask

    task automatic wait_tick(input int t);
        while (tick_no < t) @(negedge clk);
    endtask

    // two-clock low pulse, narrower than one baud tick
    task automatic fire(input int t);
        wait_tick(t);
        ir_rx_n = 1'b0;
        repeat (2) @(negedge clk);
        ir_rx_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements): cycles=200000 expected completion earlier");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int last, s, t;
        // R1: reset state, with a pulse during reset
        repeat (3) @(negedge clk);
        ir_rx_n = 1'b0;
        repeat (2) @(negedge clk);
        ir_rx_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R1 in reset", rxd, 1'b1);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 after reset", rxd, 1'b1);

        anc[0] = tick_no + 10;
        for (int i = 1; i <= NV; i++) begin
            if (TBL[i-1].exp == 1'b0) anc[i] = anc[i-1] + TPB + int'(TBL[i-1].off);
            else                      anc[i] = anc[i-1] + TPB;
        end

        fork
            begin : drive_path
                fire(anc[0]);
                for (int i = 1; i <= NV; i++) begin
                    if (TBL[i-1].drv) fire(anc[i-1] + TPB + int'(TBL[i-1].off));
                    if (TBL[i-1].gl != 8'd0) fire(anc[i] + int'(TBL[i-1].gl));
                end
            end
            begin : sample_path
                wait_tick(anc[0] + 7);
                chk("R2 before eighth tick", rxd, 1'b1);
                wait_tick(anc[0] + 8);
                chk("R2 R8 at eighth tick", rxd, 1'b0);
                wait_tick(anc[0] + 14);
                chk("R3 start bit", rxd, 1'b0);
                for (int i = 1; i <= NV; i++) begin
                    string tag;
                    if (TBL[i-1].drv && TBL[i-1].exp)  tag = "R6 out of window";
                    else if (TBL[i-1].gl >= 8'd8)      tag = "R6 gap glitch";
                    else if (TBL[i-1].gl != 8'd0)      tag = "R7 pending glitch";
                    else if (TBL[i-1].off != 8'sd0)    tag = "R5 shifted edge";
                    else if (TBL[i-1].exp)             tag = "R4 empty window";
                    else                               tag = "R3 zero bit";
                    wait_tick(anc[i] + 14);
                    chk(tag, rxd, TBL[i-1].exp);
                end
            end
        join

        // R9: twelve ones return to idle, then an off-grid edge is taken
        last = anc[NV];
        wait_tick(last + 11 * TPB + 14);
        chk("R4 long run of ones", rxd, 1'b1);
        s = last + 12 * TPB + 10;
        fire(s);
        wait_tick(s + 14);
        chk("R9 start after idle", rxd, 1'b0);

        // R1: disable while a zero is pending discards it
        s = s + 2 * TPB;
        fire(s);
        wait_tick(s + 3);
        en = 1'b0;
        wait_tick(s + 14);
        chk("R1 disable drops pending", rxd, 1'b1);
        fire(s + 20);
        wait_tick(s + 34);
        chk("R1 pulse while disabled", rxd, 1'b1);
        en = 1'b1;

        // R2: first edge after enable is accepted at any time
        t = s + 45;
        fire(t);
        wait_tick(t + 10);
        chk("R2 start after enable", rxd, 1'b0);

        // R1: synchronous reset mid-bit forces the line high
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset mid-bit", rxd, 1'b1);
        wait_tick(t + 30);
        chk("R1 stays idle after reset", rxd, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule